// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Unit

This block is the decode-stage issue control for an in-order pipeline that takes two instructions per cycle in a fixed layout. Each packet pairs an ALU or branch instruction in slot 0 with a load or store in slot 1. The compiler has already grouped the instructions into packets. Any slot it could not fill carries a nop, which the unit sees as a slot whose valid flag is low.

Each cycle the unit looks at the register fields of both slots and at the destinations of the two packets ahead of it in the execute and memory stages. From these it decides one of three outcomes: issue both slots, issue slot 0 alone and replay slot 1 on the following cycle, or issue nothing. It raises a hold signal that freezes the PC and the packet register. For every source operand of the slots that issue, it also picks the forwarding source.

The register file, execution units, memory, branch resolution and fetch sit outside the block. They reach it only as plain field inputs.

Top module: `dual_issue_gate`

## Requirements
- R1: After reset neither slot issues and hold_pkt is low. All four forwarding selects read 0, and the unit is not in the replay state, so the first packet is judged in full.
- R2: A packet with no hazard issues both valid slots in the same cycle with hold_pkt low. A stream of independent packets therefore issues at two instructions per cycle.
- R3: A slot whose valid flag is low never issues and never reads or writes any register. It cannot cause a split or a stall.
- R4: A split happens when slot 0 is valid, writes a nonzero register, and that register is read by a valid slot 1. Slot 1 reads its base always and, for a store (s1_is_load low), its data as well. On a split, the first cycle gives issue_s0=1, issue_s1=0 and hold_pkt=1. On the replay cycle that follows, issue_s0=0 and issue_s1=1, with hold_pkt low unless R5 applies.
- R5: A load-use stall applies when the execute stage holds a load with ex_ld_wr high and a nonzero ex_ld_rd, and a pending read of a valid slot names that register. The stall gives issue_s0=0, issue_s1=0 and hold_pkt=1. On a replay cycle only slot 1 reads count, and the unit stays in replay.
- R6: Each forwarding select is 2 bits: 0 = register file, 1 = execute-stage ALU result, 2 = memory-stage ALU result, 3 = memory-stage load result.
- R7: When the execute and memory stages both write the register an operand reads, the execute stage, being the youngest, wins.
- R8: Within one stage, a load writing the same register as the ALU instruction of its packet wins, because it is later in program order. In the execute stage this means a stall under R5; in the memory stage it means select 3.
- R9: Register 0 is never a dependency. It never causes a split or a stall, and an operand naming it always selects 0.
- R10: The forwarding selects of a slot that does not issue in a cycle read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_valid | input | 1 | Slot 0 holds a real instruction (low = nop) |
| s0_use_a | input | 1 | Slot 0 reads operand A |
| s0_rs_a | input | REG_W | Slot 0 operand A register |
| s0_use_b | input | 1 | Slot 0 reads operand B |
| s0_rs_b | input | REG_W | Slot 0 operand B register |
| s0_wr | input | 1 | Slot 0 writes a register |
| s0_rd | input | REG_W | Slot 0 destination register |
| s1_valid | input | 1 | Slot 1 holds a real instruction (low = nop) |
| s1_is_load | input | 1 | Slot 1 is a load (low = store) |
| s1_rs_base | input | REG_W | Slot 1 address base register |
| s1_rs_data | input | REG_W | Slot 1 store data register |
| ex_alu_wr | input | 1 | Execute-stage ALU instruction writes a register |
| ex_alu_rd | input | REG_W | Its destination |
| ex_ld_wr | input | 1 | Execute-stage load writes a register |
| ex_ld_rd | input | REG_W | Its destination |
| mem_alu_wr | input | 1 | Memory-stage ALU instruction writes a register |
| mem_alu_rd | input | REG_W | Its destination |
| mem_ld_wr | input | 1 | Memory-stage load writes a register |
| mem_ld_rd | input | REG_W | Its destination |
| issue_s0 | output | 1 | Slot 0 enters execute this cycle |
| issue_s1 | output | 1 | Slot 1 enters execute this cycle |
| hold_pkt | output | 1 | Hold the PC and the packet register |
| s0_fwd_a | output | 2 | Forwarding select, slot 0 operand A |
| s0_fwd_b | output | 2 | Forwarding select, slot 0 operand B |
| s1_fwd_base | output | 2 | Forwarding select, slot 1 base |
| s1_fwd_data | output | 2 | Forwarding select, slot 1 store data |

## Verification
The hardest situation to reach is a load-use hazard that lands on the replay cycle of a split packet. It needs a split first, and then an execute-stage load whose destination matches the slot 1 base exactly when slot 0 has already left. A directed sequence holds a split packet and drives such a load on its replay cycle. A long pseudo-random sweep then narrows register names to four values, so that producers in both stages, register 0 and nop slots collide with each other often. On every cycle the bench checks each output against a model built from the requirements, which tracks its own replay state.

// File: rtl/dig_pkg.sv
package dig_pkg;
  typedef enum logic [1:0] {
    FWD_RF      = 2'd0,
    FWD_EX_ALU  = 2'd1,
    FWD_MEM_ALU = 2'd2,
    FWD_MEM_LD  = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/dig_producer_match.sv
// Resolves one source operand against the in-flight producers.
module dig_producer_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             use_i,
  input  logic             ex_alu_wr,
  input  logic [REG_W-1:0] ex_alu_rd,
  input  logic             ex_ld_wr,
  input  logic [REG_W-1:0] ex_ld_rd,
  input  logic             mem_alu_wr,
  input  logic [REG_W-1:0] mem_alu_rd,
  input  logic             mem_ld_wr,
  input  logic [REG_W-1:0] mem_ld_rd,
  output logic [1:0]       fwd,
  output logic             ld_hit
);
  import dig_pkg::*;

  logic live;
  logic m_ex_ld, m_ex_alu, m_mem_ld, m_mem_alu;

  always_comb begin
    live      = use_i && (src != '0);
    m_ex_ld   = live && ex_ld_wr   && (ex_ld_rd   == src);
    m_ex_alu  = live && ex_alu_wr  && (ex_alu_rd  == src);
    m_mem_ld  = live && mem_ld_wr  && (mem_ld_rd  == src);
    m_mem_alu = live && mem_alu_wr && (mem_alu_rd == src);
  end

  // Youngest stage first; inside a stage the load is later in program order.
  always_comb begin
    ld_hit = m_ex_ld;
    if (m_ex_ld)        fwd = FWD_RF;
    else if (m_ex_alu)  fwd = FWD_EX_ALU;
    else if (m_mem_ld)  fwd = FWD_MEM_LD;
    else if (m_mem_alu) fwd = FWD_MEM_ALU;
    else                fwd = FWD_RF;
  end
endmodule

// File: rtl/dig_slot_split.sv
// Detects a slot 0 result consumed by slot 1 of the same packet.
module dig_slot_split #(
  parameter int REG_W = 5
) (
  input  logic             s0_valid,
  input  logic             s0_wr,
  input  logic [REG_W-1:0] s0_rd,
  input  logic             s1_valid,
  input  logic             s1_is_load,
  input  logic [REG_W-1:0] s1_rs_base,
  input  logic [REG_W-1:0] s1_rs_data,
  output logic             split_need
);
  logic prod_live, base_dep, data_dep;

  always_comb begin
    prod_live  = s0_valid && s0_wr && (s0_rd != '0);
    base_dep   = s1_rs_base == s0_rd;
    data_dep   = !s1_is_load && (s1_rs_data == s0_rd);
    split_need = prod_live && s1_valid && (base_dep || data_dep);
  end
endmodule

// File: rtl/dig_issue_seq.sv
// Issue decision and the one-bit replay state of a split packet.
module dig_issue_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic s0_valid,
  input  logic s1_valid,
  input  logic hit_s0,
  input  logic hit_s1,
  input  logic split_need,
  output logic issue_s0,
  output logic issue_s1,
  output logic hold_pkt
);
  logic replay_q, replay_d, replay_en;

  always_comb begin
    replay_d = replay_q;
    issue_s0 = 1'b0;
    issue_s1 = 1'b0;
    hold_pkt = 1'b0;
    if (replay_q) begin
      if (hit_s1) begin
        hold_pkt = 1'b1;
      end else begin
        issue_s1 = s1_valid;
        replay_d = 1'b0;
      end
    end else begin
      if (hit_s0 || hit_s1) begin
        hold_pkt = 1'b1;
      end else if (split_need) begin
        issue_s0 = 1'b1;
        hold_pkt = 1'b1;
        replay_d = 1'b1;
      end else begin
        issue_s0 = s0_valid;
        issue_s1 = s1_valid;
      end
    end
    replay_en = replay_d != replay_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replay_q <= 1'b0;
    end else if (replay_en) begin
      replay_q <= replay_d;
    end
  end
endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_valid,
  input  logic             s0_use_a,
  input  logic [REG_W-1:0] s0_rs_a,
  input  logic             s0_use_b,
  input  logic [REG_W-1:0] s0_rs_b,
  input  logic             s0_wr,
  input  logic [REG_W-1:0] s0_rd,
  input  logic             s1_valid,
  input  logic             s1_is_load,
  input  logic [REG_W-1:0] s1_rs_base,
  input  logic [REG_W-1:0] s1_rs_data,
  input  logic             ex_alu_wr,
  input  logic [REG_W-1:0] ex_alu_rd,
  input  logic             ex_ld_wr,
  input  logic [REG_W-1:0] ex_ld_rd,
  input  logic             mem_alu_wr,
  input  logic [REG_W-1:0] mem_alu_rd,
  input  logic             mem_ld_wr,
  input  logic [REG_W-1:0] mem_ld_rd,
  output logic             issue_s0,
  output logic             issue_s1,
  output logic             hold_pkt,
  output logic [1:0]       s0_fwd_a,
  output logic [1:0]       s0_fwd_b,
  output logic [1:0]       s1_fwd_base,
  output logic [1:0]       s1_fwd_data
);
  import dig_pkg::*;

  localparam int NUM_OPS   = 4;
  localparam int OPS_SLOT0 = 2;

  logic [NUM_OPS-1:0][REG_W-1:0] op_src;
  logic [NUM_OPS-1:0]            op_use;
  logic [NUM_OPS-1:0]            op_hit;
  logic [NUM_OPS-1:0][1:0]       op_fwd;
  logic                          hit_s0, hit_s1, split_need;

  always_comb begin
    op_src[0] = s0_rs_a;
    op_src[1] = s0_rs_b;
    op_src[2] = s1_rs_base;
    op_src[3] = s1_rs_data;
    op_use[0] = s0_valid && s0_use_a;
    op_use[1] = s0_valid && s0_use_b;
    op_use[2] = s1_valid;
    op_use[3] = s1_valid && !s1_is_load;
  end

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    dig_producer_match #(.REG_W(REG_W)) u_match (
      .src        (op_src[i]),
      .use_i      (op_use[i]),
      .ex_alu_wr  (ex_alu_wr),
      .ex_alu_rd  (ex_alu_rd),
      .ex_ld_wr   (ex_ld_wr),
      .ex_ld_rd   (ex_ld_rd),
      .mem_alu_wr (mem_alu_wr),
      .mem_alu_rd (mem_alu_rd),
      .mem_ld_wr  (mem_ld_wr),
      .mem_ld_rd  (mem_ld_rd),
      .fwd        (op_fwd[i]),
      .ld_hit     (op_hit[i])
    );
  end

  assign hit_s0 = |op_hit[OPS_SLOT0-1:0];
  assign hit_s1 = |op_hit[NUM_OPS-1:OPS_SLOT0];

  dig_slot_split #(.REG_W(REG_W)) u_split (
    .s0_valid   (s0_valid),
    .s0_wr      (s0_wr),
    .s0_rd      (s0_rd),
    .s1_valid   (s1_valid),
    .s1_is_load (s1_is_load),
    .s1_rs_base (s1_rs_base),
    .s1_rs_data (s1_rs_data),
    .split_need (split_need)
  );

  dig_issue_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .s0_valid   (s0_valid),
    .s1_valid   (s1_valid),
    .hit_s0     (hit_s0),
    .hit_s1     (hit_s1),
    .split_need (split_need),
    .issue_s0   (issue_s0),
    .issue_s1   (issue_s1),
    .hold_pkt   (hold_pkt)
  );

  always_comb begin
    s0_fwd_a    = issue_s0 ? op_fwd[0] : FWD_RF;
    s0_fwd_b    = issue_s0 ? op_fwd[1] : FWD_RF;
    s1_fwd_base = issue_s1 ? op_fwd[2] : FWD_RF;
    s1_fwd_data = issue_s1 ? op_fwd[3] : FWD_RF;
  end
endmodule

// File: rtl/dig_checker.sv
module dig_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s0_valid,
  input logic             s0_use_a,
  input logic [REG_W-1:0] s0_rs_a,
  input logic             s1_valid,
  input logic [REG_W-1:0] s1_rs_base,
  input logic             ex_ld_wr,
  input logic [REG_W-1:0] ex_ld_rd,
  input logic             issue_s0,
  input logic             issue_s1,
  input logic             hold_pkt,
  input logic [1:0]       s0_fwd_a,
  input logic [1:0]       s0_fwd_b,
  input logic [1:0]       s1_fwd_base,
  input logic [1:0]       s1_fwd_data
);
  p_ipc2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_s0 && issue_s1) |-> !hold_pkt);

  p_nop_s0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_valid |-> !issue_s0);

  p_nop_s1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |-> !issue_s1);

  p_split_replay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_s0 && hold_pkt) |=> !issue_s0);

  p_hold_s1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pkt |-> !issue_s1);

  p_ldu_s1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ld_wr && ex_ld_rd != '0 && s1_valid && s1_rs_base == ex_ld_rd) |-> !issue_s1);

  p_ldu_s0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ld_wr && ex_ld_rd != '0 && s0_valid && s0_use_a && s0_rs_a == ex_ld_rd) |-> !issue_s0);

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_rs_a == '0) |-> (s0_fwd_a == 2'd0));

  p_idle_fwd_s0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_s0 |-> (s0_fwd_a == 2'd0 && s0_fwd_b == 2'd0));

  p_idle_fwd_s1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_s1 |-> (s1_fwd_base == 2'd0 && s1_fwd_data == 2'd0));
endmodule

bind dual_issue_gate dig_checker #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s0_valid    (s0_valid),
  .s0_use_a    (s0_use_a),
  .s0_rs_a     (s0_rs_a),
  .s1_valid    (s1_valid),
  .s1_rs_base  (s1_rs_base),
  .ex_ld_wr    (ex_ld_wr),
  .ex_ld_rd    (ex_ld_rd),
  .issue_s0    (issue_s0),
  .issue_s1    (issue_s1),
  .hold_pkt    (hold_pkt),
  .s0_fwd_a    (s0_fwd_a),
  .s0_fwd_b    (s0_fwd_b),
  .s1_fwd_base (s1_fwd_base),
  .s1_fwd_data (s1_fwd_data)
);

// File: tb/dual_issue_gate_bench.sv
module dual_issue_gate_bench;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic s0_valid, s0_use_a, s0_use_b, s0_wr;
  logic [RW-1:0] s0_rs_a, s0_rs_b, s0_rd;
  logic s1_valid, s1_is_load;
  logic [RW-1:0] s1_rs_base, s1_rs_data;
  logic ex_alu_wr, ex_ld_wr, mem_alu_wr, mem_ld_wr;
  logic [RW-1:0] ex_alu_rd, ex_ld_rd, mem_alu_rd, mem_ld_rd;
  logic issue_s0, issue_s1, hold_pkt;
  logic [1:0] s0_fwd_a, s0_fwd_b, s1_fwd_base, s1_fwd_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit m_replay = 0;
  bit exp_hold = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  dual_issue_gate #(.REG_W(RW)) u_dual_issue_gate (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Operand model from R6-R9: youngest stage first, load before ALU in a stage.
  task automatic op_model(input logic [RW-1:0] src, input bit used,
                          output int f, output bit hit);
    bit live;
    live = used && (src != 0);
    hit = 0; f = 0;
    if (!live) f = 0;
    else if (ex_ld_wr && ex_ld_rd == src) hit = 1;
    else if (ex_alu_wr && ex_alu_rd == src) f = 1;
    else if (mem_ld_wr && mem_ld_rd == src) f = 3;
    else if (mem_alu_wr && mem_alu_rd == src) f = 2;
  endtask

  // Called after inputs settle, away from the clock edge.
  task automatic eval(input string req);
    int fa, fb, fbase, fdata;
    bit ha, hb, hbase, hdata, h0, h1, split, e0, e1, st, nxt;
    op_model(s0_rs_a, s0_valid && s0_use_a, fa, ha);
    op_model(s0_rs_b, s0_valid && s0_use_b, fb, hb);
    op_model(s1_rs_base, s1_valid, fbase, hbase);
    op_model(s1_rs_data, s1_valid && !s1_is_load, fdata, hdata);
    h0 = ha | hb; h1 = hbase | hdata;
    split = s0_valid && s0_wr && s0_rd != 0 && s1_valid &&
            (s1_rs_base == s0_rd || (!s1_is_load && s1_rs_data == s0_rd));
    e0 = 0; e1 = 0; st = 0; nxt = m_replay;
    if (m_replay) begin
      if (h1) st = 1;
      else begin e1 = s1_valid; nxt = 0; end
    end else begin
      if (h0 || h1) st = 1;
      else if (split) begin e0 = 1; st = 1; nxt = 1; end
      else begin e0 = s0_valid; e1 = s1_valid; end
    end
    chk(req, "issue_s0", issue_s0, e0);
    chk(req, "issue_s1", issue_s1, e1);
    chk(req, "hold_pkt", hold_pkt, st);
    chk("R6/R10", "s0_fwd_a", s0_fwd_a, e0 ? fa : 0);
    chk("R6/R10", "s0_fwd_b", s0_fwd_b, e0 ? fb : 0);
    chk("R6/R10", "s1_fwd_base", s1_fwd_base, e1 ? fbase : 0);
    chk("R6/R10", "s1_fwd_data", s1_fwd_data, e1 ? fdata : 0);
    m_replay = nxt;
    exp_hold = st;
  endtask

  task automatic clear_all();
    s0_valid = 0; s0_use_a = 0; s0_use_b = 0; s0_wr = 0;
    s0_rs_a = 0; s0_rs_b = 0; s0_rd = 0;
    s1_valid = 0; s1_is_load = 0; s1_rs_base = 0; s1_rs_data = 0;
    ex_alu_wr = 0; ex_ld_wr = 0; mem_alu_wr = 0; mem_ld_wr = 0;
    ex_alu_rd = 0; ex_ld_rd = 0; mem_alu_rd = 0; mem_ld_rd = 0;
  endtask

  task automatic set_s0(input logic [RW-1:0] a, input logic [RW-1:0] b, input logic [RW-1:0] d);
    s0_valid = 1; s0_use_a = 1; s0_use_b = 1; s0_wr = 1;
    s0_rs_a = a; s0_rs_b = b; s0_rd = d;
  endtask

  task automatic set_s1(input bit ld, input logic [RW-1:0] base, input logic [RW-1:0] data);
    s1_valid = 1; s1_is_load = ld; s1_rs_base = base; s1_rs_data = data;
  endtask

  function automatic logic [31:0] step_lfsr(input logic [31:0] v);
    logic [31:0] x;
    x = v ^ (v << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [RW-1:0] rreg(input logic [1:0] r);
    return {{(RW-2){1'b0}}, r};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    clear_all();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R1: idle after reset
    chk("R1", "issue_s0", issue_s0, 0);
    chk("R1", "issue_s1", issue_s1, 0);
    chk("R1", "hold_pkt", hold_pkt, 0);
    chk("R1", "s1_fwd_base", s1_fwd_base, 0);

    // R1: first packet after reset is a split, so replay state was clear
    @(negedge clk); set_s0(5'd1, 5'd2, 5'd3); set_s1(1, 5'd3, 5'd0); #2;
    chk("R1", "issue_s0 first", issue_s0, 1);
    eval("R4");
    // R4: replay cycle, slot 0 now in execute
    @(negedge clk); ex_alu_wr = 1; ex_alu_rd = 5'd3; #2;
    chk("R4", "replay issue_s1", issue_s1, 1);
    chk("R4", "replay fwd base", s1_fwd_base, 1);
    eval("R4");

    // R2: independent packets back to back
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); clear_all();
      set_s0(5'd4, 5'd5, 5'd6); set_s1(k[0], 5'd7, 5'd8); #2;
      chk("R2", "both issue", {issue_s0, issue_s1, hold_pkt}, 3'b110);
      eval("R2");
    end

    // R3: nop slot 1 next to a producer, nop slot 0 with load-use regs
    @(negedge clk); clear_all(); set_s0(5'd1, 5'd1, 5'd9); s1_rs_base = 5'd9; #2;
    eval("R3");
    @(negedge clk); clear_all(); set_s1(0, 5'd4, 5'd4);
    s0_rs_a = 5'd2; s0_use_a = 1; ex_ld_wr = 1; ex_ld_rd = 5'd2; #2;
    eval("R3");

    // R5: load-use into slot 0, then into slot 1
    @(negedge clk); clear_all(); set_s0(5'd10, 5'd1, 5'd2); set_s1(1, 5'd4, 5'd0);
    ex_ld_wr = 1; ex_ld_rd = 5'd10; #2;
    chk("R5", "slot0 lu hold", {issue_s0, issue_s1, hold_pkt}, 3'b001);
    eval("R5");
    @(negedge clk); clear_all(); set_s0(5'd1, 5'd1, 5'd2); set_s1(0, 5'd4, 5'd11);
    ex_ld_wr = 1; ex_ld_rd = 5'd11; #2;
    eval("R5");

    // R5: load-use on the replay cycle of a split
    @(negedge clk); clear_all(); set_s0(5'd1, 5'd1, 5'd12); set_s1(0, 5'd12, 5'd13); #2;
    eval("R4");
    @(negedge clk); ex_ld_wr = 1; ex_ld_rd = 5'd12; #2;
    chk("R5", "replay lu hold", {issue_s0, issue_s1, hold_pkt}, 3'b001);
    eval("R5");
    @(negedge clk); ex_ld_wr = 0; ex_alu_wr = 1; ex_alu_rd = 5'd12; #2;
    eval("R4");

    // R7 / R8: priority among producers
    @(negedge clk); clear_all(); set_s0(5'd14, 5'd15, 5'd0); set_s1(1, 5'd16, 5'd0);
    ex_alu_wr = 1; ex_alu_rd = 5'd14; mem_alu_wr = 1; mem_alu_rd = 5'd14;
    mem_ld_wr = 1; mem_ld_rd = 5'd15; #2;
    chk("R7", "ex over mem", s0_fwd_a, 1);
    chk("R8", "mem load over alu", s0_fwd_b, 3);
    eval("R7");
    @(negedge clk); clear_all(); set_s0(5'd17, 5'd1, 5'd2); set_s1(1, 5'd3, 5'd0);
    ex_alu_wr = 1; ex_alu_rd = 5'd17; ex_ld_wr = 1; ex_ld_rd = 5'd17; #2;
    chk("R8", "ex load over alu stalls", hold_pkt, 1);
    eval("R8");

    // R9: register 0 never forwarded, never a split
    @(negedge clk); clear_all(); set_s0(5'd0, 5'd0, 5'd0); set_s1(0, 5'd0, 5'd0);
    ex_alu_wr = 1; ex_ld_wr = 1; mem_alu_wr = 1; mem_ld_wr = 1; #2;
    chk("R9", "zero reg both issue", {issue_s0, issue_s1, hold_pkt}, 3'b110);
    eval("R9");

    // Pseudo-random sweep over four register names; packet held while stalled
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      lfsr = step_lfsr(lfsr);
      if (!exp_hold) begin
        s0_valid = lfsr[0] | lfsr[1]; s0_use_a = lfsr[2]; s0_use_b = lfsr[3];
        s0_wr = lfsr[4]; s0_rs_a = rreg(lfsr[6:5]); s0_rs_b = rreg(lfsr[8:7]);
        s0_rd = rreg(lfsr[10:9]);
        s1_valid = lfsr[11] | lfsr[12]; s1_is_load = lfsr[13];
        s1_rs_base = rreg(lfsr[15:14]); s1_rs_data = rreg(lfsr[17:16]);
        lfsr = step_lfsr(lfsr);
      end
      ex_alu_wr = lfsr[18]; ex_alu_rd = rreg(lfsr[20:19]);
      ex_ld_wr = lfsr[21] & lfsr[22]; ex_ld_rd = rreg(lfsr[24:23]);
      mem_alu_wr = lfsr[25]; mem_alu_rd = rreg(lfsr[27:26]);
      mem_ld_wr = lfsr[28]; mem_ld_rd = rreg(lfsr[30:29]);
      #2;
      eval(m_replay ? "R4" : "R2/R5");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule